// File: doc/BRIEF.md
# Configuration Header Masked Write Unit

This block stores the configuration space of a PCI-style function as an array of byte registers. The lower 64 bytes form the standard header. Software reaches the array through single-cycle requests that carry a byte offset, a length of one to four bytes and up to four data bytes. A fixed per-byte write mask decides which header bits software can change. The upper status byte works as write-one-to-clear. Bytes above the header are plain storage.

A request is checked before it touches anything. A length of zero, a length above four, or a request whose last byte falls past the end of the array is answered with an error and changes nothing. Reads return the addressed bytes in little-endian lane order. The block also watches the power-management control word: a write that starts exactly at that word and leaves its state field at 3 sets a flag that stays set until reset.

Top module: `cfgspace_wr_unit`

## Requirements
- R1: When reset is applied, byte i of the array loads byte i of the INIT_IMAGE parameter (bits 8i+7..8i), and d3_entered goes to 0.
- R2: Every request (req_valid high at a clock edge) gets exactly one response, with rsp_valid high in the following cycle. A good read places the byte at offset+k in bits 8k+7..8k for k below req_len, and puts zero in the lanes at or above req_len. A write response carries zero data.
- R3: A request with req_len of 0 or above 4, or with offset+req_len above SPACE_BYTES, responds with rsp_error=1 and zero data, and leaves every byte and d3_entered unchanged.
- R4: Header bytes with write masks: 0x04 takes 0xFF, 0x05 takes 0x07, 0x06 takes 0x00, 0x0C takes 0xFF, and 0x10 through 0x27 take 0xFF. A written byte becomes (old AND NOT mask) OR (data AND mask).
- R5: Byte 0x30 has mask 0x01, 0x31 has 0xF8, 0x32 and 0x33 have 0xFF, and 0x3C has 0xFF. Every other byte below 0x40 is read-only.
- R6: At byte 0x07 the mask is 0xF9. Each masked bit written with 1 clears, a masked bit written with 0 keeps its value, and unmasked bits never change. No bit of this byte can go from 0 to 1 except through reset.
- R7: A byte at offset 0x40 or above takes the written data unchanged.
- R8: A write that starts at offset PM_OFS, where PM_OFS is not zero, and leaves bits 1..0 of that byte at 3 sets d3_entered. A write that only covers PM_OFS without starting there does not set it. Once set, d3_entered stays set until reset.
- R9: A multi-byte write applies the rule of each byte's own offset to that byte, including writes that are unaligned or that span a header/plain-storage boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | AW | Byte offset of the first byte |
| req_len | input | 3 | Number of bytes, 1 to 4 |
| req_wdata | input | 32 | Write data, the first byte in bits 7..0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_error | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, little-endian, unused lanes zero |
| d3_entered | output | 1 | Sticky flag for a request to enter D3hot |

## Verification
The embedded assertions check the following on every cycle:
- one response per request, in the next cycle;
- zero data on an error;
- the status low byte never changes;
- no status-high bit is ever set after reset;
- the D3 flag is sticky and only rises after a write that starts at the power-management offset.

The exact merged value of each masked byte can only be shown by the bench's scenarios against its behavioural model. The same holds for the little-endian lane packing, the unchanged state after a rejected request, and the case where a write covers the power-management byte without starting on it.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned STATUS_HI_OFS = 7;

  function automatic logic [7:0] hdr_mask(input int unsigned ofs);
    logic [7:0] m;
    m = 8'h00;
    if (ofs >= 32'h10 && ofs <= 32'h27) m = 8'hFF;
    else begin
      case (ofs)
        32'h04, 32'h0C, 32'h3C, 32'h32, 32'h33: m = 8'hFF;
        32'h05: m = 8'h07;
        32'h07: m = 8'hF9;
        32'h30: m = 8'h01;
        32'h31: m = 8'hF8;
        default: m = 8'h00;
      endcase
    end
    return m;
  endfunction

  function automatic logic [7:0] merge_byte(input int unsigned ofs, input int unsigned hdr,
                                            input logic [7:0] old, input logic [7:0] din);
    logic [7:0] m;
    if (ofs >= hdr) return din;
    m = hdr_mask(ofs);
    if (ofs == STATUS_HI_OFS) return old & ~(din & m);
    return (old & ~m) | (din & m);
  endfunction
endpackage

// File: rtl/cfgw_access_check.sv
module cfgw_access_check #(
  parameter int SPACE_BYTES = 128,
  parameter int AW = 7
) (
  input  logic [AW-1:0] offset,
  input  logic [2:0]    len,
  output logic          ok
);
  logic [AW+3:0] end_pos;
  assign end_pos = {4'b0000, offset} + {{(AW+1){1'b0}}, len};
  assign ok = (len != 3'd0) && (len <= 3'd4) && (32'(end_pos) <= SPACE_BYTES);
endmodule

// File: rtl/cfgw_lane.sv
module cfgw_lane import cfgw_pkg::*; #(
  parameter int AW = 7,
  parameter int HDR_BYTES = 64
) (
  input  logic [AW:0] idx,
  input  logic [7:0]  old_byte,
  input  logic [7:0]  din,
  output logic [7:0]  nxt
);
  assign nxt = merge_byte(32'(idx), 32'(HDR_BYTES), old_byte, din);
endmodule

// File: rtl/cfgw_pm_watch.sv
module cfgw_pm_watch #(
  parameter int PM_OFS = 68,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_commit,
  input  logic [AW-1:0] offset,
  input  logic [7:0]    first_nxt,
  output logic          d3_entered
);
  logic pm_hit;

  generate
    if (PM_OFS != 0) begin : g_pm
      assign pm_hit = wr_commit && (offset == AW'(PM_OFS)) && (first_nxt[1:0] == 2'b11);
    end else begin : g_nopm
      assign pm_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) d3_entered <= 1'b0;
    else if (pm_hit) d3_entered <= 1'b1;
  end

  // R8: the flag never drops while out of reset
  p_d3_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d3_entered |=> d3_entered);
  // R8: the flag only rises after a committed write starting at PM_OFS
  p_d3_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d3_entered) |-> $past(wr_commit && offset == AW'(PM_OFS)));
endmodule

// File: rtl/cfgspace_wr_unit.sv
module cfgspace_wr_unit import cfgw_pkg::*; #(
  parameter int SPACE_BYTES = 128,
  parameter int HDR_BYTES = 64,
  parameter int PM_OFS = 68,
  parameter logic [SPACE_BYTES*8-1:0] INIT_IMAGE = '0,
  localparam int AW = $clog2(SPACE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_offset,
  input  logic [2:0]    req_len,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_error,
  output logic [31:0]   rsp_rdata,
  output logic          d3_entered
);
  localparam int AW1 = AW + 1;

  logic [7:0]    mem [SPACE_BYTES];
  logic          acc_ok;
  logic          wr_commit;
  logic [AW:0]   lane_idx [LANES];
  logic [7:0]    old_b    [LANES];
  logic [7:0]    lane_nxt [LANES];
  logic [LANES-1:0] lane_sel;
  logic [LANES-1:0] lane_we;
  logic [31:0]   rd_word;

  cfgw_access_check #(.SPACE_BYTES(SPACE_BYTES), .AW(AW)) u_chk (
    .offset(req_offset), .len(req_len), .ok(acc_ok));

  assign wr_commit = req_valid && req_write && acc_ok;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic live;
      assign lane_idx[k] = {1'b0, req_offset} + AW1'(k);
      assign live        = 32'(lane_idx[k]) < SPACE_BYTES;
      assign old_b[k]    = live ? mem[lane_idx[k][AW-1:0]] : 8'h00;
      assign lane_sel[k] = 3'(k) < req_len;
      assign lane_we[k]  = wr_commit && lane_sel[k];
      assign rd_word[8*k +: 8] = lane_sel[k] ? old_b[k] : 8'h00;
      cfgw_lane #(.AW(AW), .HDR_BYTES(HDR_BYTES)) u_lane (
        .idx(lane_idx[k]), .old_byte(old_b[k]), .din(req_wdata[8*k +: 8]), .nxt(lane_nxt[k]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE_BYTES; i++) mem[i] <= INIT_IMAGE[8*i +: 8];
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_error <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_word : 32'h0;
      for (int k = 0; k < LANES; k++)
        if (lane_we[k]) mem[lane_idx[k][AW-1:0]] <= lane_nxt[k];
    end
  end

  cfgw_pm_watch #(.PM_OFS(PM_OFS), .AW(AW)) u_pm (
    .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .offset(req_offset),
    .first_nxt(lane_nxt[0]), .d3_entered(d3_entered));

  // R2: one response per request, in the next cycle
  p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3: rejected requests return zero data
  p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_error) |-> (rsp_rdata == 32'h0));
  // R5: the status low byte is read-only
  p_status_lo_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mem[6]));
  // R6: no bit of the status high byte is ever set after reset
  p_w1c_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((mem[7] & ~$past(mem[7])) == 8'h00));
endmodule

// File: tb/sim_cfgspace_wr_unit.sv
`timescale 1ns/1ps
module sim_cfgspace_wr_unit;
  localparam int SP = 128;
  localparam int PMO = 68;

  function automatic logic [SP*8-1:0] mk_img();
    logic [SP*8-1:0] v;
    for (int i = 0; i < SP; i++) v[8*i +: 8] = 8'((i * 29 + 7) % 256);
    return v;
  endfunction
  localparam logic [SP*8-1:0] IMG = mk_img();

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_offset = '0;
  logic [2:0] req_len = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_error, d3_entered;
  logic [31:0] rsp_rdata;
  string req_tag = "R2";

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  cfgspace_wr_unit #(.SPACE_BYTES(SP), .HDR_BYTES(64), .PM_OFS(PMO), .INIT_IMAGE(IMG)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .d3_entered(d3_entered));

  // ---------------- behavioural reference model ----------------
  logic [7:0] ref_mem [SP];
  bit ref_d3 = 0;
  bit exp_valid = 0, exp_err = 0;
  logic [31:0] exp_data = '0;
  string exp_tag = "R2";

  function automatic logic [7:0] bmask(int o);
    if (o == 4 || o == 12 || o == 60 || o == 50 || o == 51) return 8'hFF;
    if (o >= 16 && o < 40) return 8'hFF;
    if (o == 5) return 8'h07;
    if (o == 7) return 8'hF9;
    if (o == 48) return 8'h01;
    if (o == 49) return 8'hF8;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SP; i++) ref_mem[i] = IMG[8*i +: 8];
      ref_d3 = 0; exp_valid = 0; exp_err = 0; exp_data = '0;
    end else begin
      exp_valid = req_valid;
      exp_err = 0; exp_data = '0; exp_tag = req_tag;
      if (req_valid) begin
        int o, l;
        o = int'(req_offset); l = int'(req_len);
        if (!(l >= 1 && l <= 4 && o + l <= SP)) exp_err = 1;
        else if (!req_write) begin
          for (int k = 0; k < l; k++) exp_data[8*k +: 8] = ref_mem[o + k];
        end else begin
          for (int k = 0; k < l; k++) begin
            logic [7:0] d, m, nb;
            d = req_wdata[8*k +: 8]; m = bmask(o + k); nb = ref_mem[o + k];
            for (int b = 0; b < 8; b++) begin
              if (o + k >= 64) nb[b] = d[b];
              else if (m[b]) nb[b] = (o + k == 7) ? (d[b] ? 1'b0 : nb[b]) : d[b];
            end
            ref_mem[o + k] = nb;
          end
          if (o == PMO && ref_mem[PMO][1:0] == 2'b11) ref_d3 = 1;
        end
      end
    end
  end

  // ---------------- comparison every cycle ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rsp_valid !== exp_valid) begin
        bad++; $display("FAIL R2 rsp_valid act=%0b exp=%0b", rsp_valid, exp_valid);
      end
      if (exp_valid) begin
        total++;
        if (rsp_error !== exp_err || rsp_rdata !== exp_data) begin
          bad++;
          $display("FAIL %s rsp err/data act=%0b/%h exp=%0b/%h", exp_tag, rsp_error, rsp_rdata, exp_err, exp_data);
        end
      end
      total++;
      if (d3_entered !== ref_d3) begin
        bad++; $display("FAIL R8 d3_entered act=%0b exp=%0b", d3_entered, ref_d3);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input bit wr, input int off, input int len, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_offset = 7'(off); req_len = 3'(len);
    req_wdata = d; req_tag = tag;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); req_valid = 0;
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); req_valid = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < SP; a += 4) acc(0, a, 4, 32'h0, tag);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    total++;
    if (d3_entered !== 1'b0) begin bad++; $display("FAIL R1 d3 after reset act=%0b exp=0", d3_entered); end
    read_all("R1");
    // R2: partial reads and lane zeroing
    acc(0, 5, 3, 0, "R2"); acc(0, 127, 1, 0, "R2"); acc(0, 62, 2, 0, "R2"); acc(0, 9, 1, 0, "R2");
    // R3: rejects leave state unchanged
    acc(1, 64, 0, 32'hFFFF_FFFF, "R3"); acc(1, 64, 5, 32'h1234_5678, "R3");
    acc(1, 126, 4, 32'hAAAA_AAAA, "R3"); acc(0, 125, 4, 0, "R3"); acc(0, 0, 7, 0, "R3");
    acc(1, 4, 0, 32'hFFFF_FFFF, "R3");
    acc(0, 124, 4, 0, "R3"); acc(0, 64, 4, 0, "R3"); acc(0, 4, 4, 0, "R3");
    // R4: command, cache line, base address bytes
    acc(1, 4, 2, 32'h0000_FFFF, "R4"); acc(0, 4, 4, 0, "R4");
    acc(1, 4, 2, 32'h0000_0000, "R4"); acc(0, 4, 4, 0, "R4");
    acc(1, 12, 4, 32'hFFFF_FFFF, "R4"); acc(0, 12, 4, 0, "R4");
    for (int a = 16; a < 40; a += 4) begin
      acc(1, a, 4, 32'hFFFF_FFFF, "R4"); acc(0, a, 4, 0, "R4");
      acc(1, a, 4, 32'h5A00_C3A5 ^ 32'(a), "R4"); acc(0, a, 4, 0, "R4");
    end
    // R5: expansion ROM, interrupt line, read-only bytes
    acc(1, 48, 4, 32'hFFFF_FFFF, "R5"); acc(0, 48, 4, 0, "R5");
    acc(1, 48, 4, 32'h0000_0000, "R5"); acc(0, 48, 4, 0, "R5");
    acc(1, 60, 4, 32'hFFFF_FFFF, "R5"); acc(0, 60, 4, 0, "R5");
    acc(1, 0, 4, 32'hFFFF_FFFF, "R5"); acc(1, 8, 4, 32'h0, "R5");
    acc(1, 40, 4, 32'h0, "R5"); acc(1, 52, 4, 32'hFFFF_FFFF, "R5");
    read_all("R5");
    // R6: status high byte write-one-to-clear
    acc(1, 7, 1, 32'h0000_0000, "R6"); acc(0, 4, 4, 0, "R6");
    acc(1, 7, 1, 32'h0000_0010, "R6"); acc(0, 4, 4, 0, "R6");
    acc(1, 4, 4, 32'hFF00_0000, "R6"); acc(0, 4, 4, 0, "R6");
    // R7: plain storage above the header
    acc(1, 64, 4, 32'hDEAD_BEEF, "R7"); acc(1, 100, 3, 32'h0012_3456, "R7");
    acc(1, 127, 1, 32'h0000_00A5, "R7");
    acc(0, 64, 4, 0, "R7"); acc(0, 100, 4, 0, "R7"); acc(0, 124, 4, 0, "R7");
    // R9: spanning and unaligned writes
    acc(1, 62, 4, 32'h1122_3344, "R9"); acc(0, 60, 4, 0, "R9"); acc(0, 64, 4, 0, "R9");
    acc(1, 5, 3, 32'h00FF_FFFF, "R9"); acc(0, 4, 4, 0, "R9");
    acc(1, 46, 4, 32'hFFFF_FFFF, "R9"); acc(0, 48, 4, 0, "R9"); acc(0, 44, 4, 0, "R9");
    // R8: power-management detection
    acc(1, PMO - 1, 4, 32'h0000_0300, "R8");
    acc(1, PMO, 2, 32'h0000_0002, "R8");
    acc(1, PMO + 1, 1, 32'h0000_0003, "R8");
    idle(2);
    acc(1, PMO, 2, 32'h0000_0003, "R8");
    idle(2);
    acc(1, PMO, 2, 32'h0000_0000, "R8");
    idle(2);
    do_reset();
    @(negedge clk);
    total++;
    if (d3_entered !== 1'b0) begin bad++; $display("FAIL R1 d3 after second reset act=%0b exp=0", d3_entered); end
    read_all("R1");
    // R9: random mix
    for (int n = 0; n < 400; n++) begin
      int o, l;
      o = int'($urandom_range(0, 127));
      l = int'($urandom_range(0, 5));
      acc($urandom_range(0, 1) == 1, o, l, $urandom, "R9");
    end
    read_all("R9");
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule